// File: doc/BRIEF.md
# Chained Two-Channel Byte Copy Engine

This block copies a block of bytes from one memory region to another without CPU data movement. Two single-address channels are chained through a one-byte staging location. Channel 0 reads a byte from an incrementing source pointer and writes it to the staging address. Channel 1 reads the staging address and writes the byte to an incrementing destination pointer. One periodic trigger pulse, such as a timer underflow, raises a request on both channels at once. Fixed priority then runs channel 0's half of the copy before channel 1's half.

Each half of a copy is a read cycle followed at once by a write cycle. The block steals these two cycles from the CPU-side bus master, and it takes the bus only when that master is not in the middle of a transfer. CPU cycles can therefore fall between channel 0's half and channel 1's half of the same byte. Software loads the pointers, the staging address and the byte count through a small configuration port while both channels are disabled. It then arms each channel with an enable bit.

The control state machine has five states. ST_IDLE holds the bus for the CPU. ST_RD0 and ST_WR0 form channel 0's read and write cycles. ST_RD1 and ST_WR1 form channel 1's read and write cycles. Its transitions are as follows:
- ST_IDLE goes to ST_RD0 when channel 0 has a pending request and the CPU is idle.
- Failing that, ST_IDLE goes to ST_RD1 when channel 1 has a pending request, channel 1 is behind channel 0, and the CPU is idle.
- ST_RD0 always goes to ST_WR0, and ST_RD1 always goes to ST_WR1.
- ST_WR0 and ST_WR1 always return to ST_IDLE, and each completes its channel's transfer.

Top module: `dma_chain_top`

## Requirements
- R1: After reset the block drives no read or write strobe, does not own the bus, both channels are disabled and both done flags are low.
- R2: Configuration writes to select 0 (source pointer), 1 (staging address), 2 (destination pointer) and 3 (byte count, loaded into both channels) take effect only while both enable bits are 0; otherwise they are ignored. Select 4 sets the enables at any time: data bit 0 arms channel 0, bit 1 arms channel 1.
- R3: A trigger pulse sets the pending flag of each armed channel whose count is nonzero. A trigger that arrives while a channel's flag is already set is not counted again.
- R4: Channel 0 is served before channel 1. Channel 0 reads the source pointer and writes the staging address. Channel 1 reads the staging address and writes the destination pointer. Both pointers advance by one after each transfer.
- R5: The bus is taken only from the idle state, and only when the CPU busy input is low. A read cycle is always followed in the next cycle by the matching write cycle, and the bus-owned output is high during both cycles.
- R6: While the CPU busy input is high after channel 0's half of a copy, channel 1's half waits and no bus cycle is issued.
- R7: Channel 1 never performs more transfers than channel 0. With only channel 1 armed, a trigger produces no bus cycle.
- R8: Each transfer decrements its channel's count. A channel's done flag is high while it is armed and its count is zero, and triggers after that move no data.
- R9: Each trigger pulse moves exactly one byte from source to destination, so a 128-byte block needs 128 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_data_i | input | AW | Configuration write data |
| trig_i | input | 1 | Copy trigger pulse, shared by both channels |
| cpu_busy_i | input | 1 | CPU-side master is mid-transfer |
| dma_bus_o | output | 1 | Block owns the bus this cycle |
| mem_addr_o | output | AW | Bus address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the read cycle |
| done_o | output | 2 | Per-channel done flags |

## Verification
The hardest case to reach from the ports is a CPU transfer that lands between the two halves of one copy. At that point the staging byte is written but the destination is not. The stimulus watches for channel 0's write strobe and raises the CPU busy input on that same cycle. This parks the engine in ST_IDLE with only channel 1 pending. The bench then checks that exactly one write was issued before it releases the busy input and confirms that the destination byte arrives. A second scenario arms only channel 1 so that the ordering guard, not priority, is what blocks it.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD0  = 3'd1,
        ST_WR0  = 3'd2,
        ST_RD1  = 3'd3,
        ST_WR1  = 3'd4
    } dma_state_e;

    localparam logic [2:0] SEL_SRC = 3'd0;
    localparam logic [2:0] SEL_TMP = 3'd1;
    localparam logic [2:0] SEL_DST = 3'd2;
    localparam logic [2:0] SEL_CNT = 3'd3;
    localparam logic [2:0] SEL_EN  = 3'd4;

endpackage

// File: rtl/dma_chan.sv
module dma_chan #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          trig_i,
    input  logic          ld_ptr_i,
    input  logic          ld_cnt_i,
    input  logic [AW-1:0] cfg_data_i,
    input  logic          step_i,
    output logic [AW-1:0] ptr_o,
    output logic [CW-1:0] cnt_o,
    output logic          pend_o,
    output logic          done_o
);
    logic cnt_zero;
    assign cnt_zero = (cnt_o == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_o  <= '0;
            cnt_o  <= '0;
            pend_o <= 1'b0;
        end else begin
            if (ld_ptr_i)
                ptr_o <= cfg_data_i;
            else if (step_i)
                ptr_o <= ptr_o + AW'(1);

            if (ld_cnt_i)
                cnt_o <= cfg_data_i[CW-1:0];
            else if (step_i)
                cnt_o <= cnt_o - CW'(1);

            if (!en_i || step_i)
                pend_o <= 1'b0;
            else if (trig_i && !cnt_zero)
                pend_o <= 1'b1;
        end
    end

    assign done_o = en_i && cnt_zero;
endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
    import dma_chain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req0_i,
    input  logic       req1_i,
    input  logic       cpu_busy_i,
    output dma_state_e state_o,
    output logic       step0_o,
    output logic       step1_o,
    output logic       rd_o,
    output logic       wr_o,
    output logic       own_o
);
    dma_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= state_d;
    end

    always_comb begin
        state_d = state_o;
        unique case (state_o)
            ST_IDLE: begin
                if (!cpu_busy_i && req0_i)      state_d = ST_RD0;
                else if (!cpu_busy_i && req1_i) state_d = ST_RD1;
            end
            ST_RD0:  state_d = ST_WR0;
            ST_WR0:  state_d = ST_IDLE;
            ST_RD1:  state_d = ST_WR1;
            ST_WR1:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        step0_o = (state_o == ST_WR0);
        step1_o = (state_o == ST_WR1);
        rd_o    = (state_o == ST_RD0) || (state_o == ST_RD1);
        wr_o    = step0_o || step1_o;
        own_o   = rd_o || wr_o;
    end
endmodule

// File: rtl/dma_chain_top.sv
module dma_chain_top
    import dma_chain_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we_i,
    input  logic [2:0]    cfg_sel_i,
    input  logic [AW-1:0] cfg_data_i,
    input  logic          trig_i,
    input  logic          cpu_busy_i,
    output logic          dma_bus_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [7:0]    mem_wdata_o,
    input  logic [7:0]    mem_rdata_i,
    output logic [1:0]    done_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] en_q;
    logic [AW-1:0]  tmp_q;
    logic [7:0]     data_q;
    logic           cfg_ok;
    logic [AW-1:0]  ptr_w [NCH];
    logic [CW-1:0]  cnt_w [NCH];
    logic [NCH-1:0] pend_w;
    logic [NCH-1:0] step_w;
    dma_state_e     state;

    assign cfg_ok = cfg_we_i && (en_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            tmp_q  <= '0;
            data_q <= '0;
        end else begin
            if (cfg_we_i && cfg_sel_i == SEL_EN) en_q  <= cfg_data_i[NCH-1:0];
            if (cfg_ok && cfg_sel_i == SEL_TMP)  tmp_q <= cfg_data_i;
            if (mem_rd_o)                        data_q <= mem_rdata_i;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [2:0] PTR_SEL = (i == 0) ? SEL_SRC : SEL_DST;
        dma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (en_q[i]),
            .trig_i     (trig_i),
            .ld_ptr_i   (cfg_ok && cfg_sel_i == PTR_SEL),
            .ld_cnt_i   (cfg_ok && cfg_sel_i == SEL_CNT),
            .cfg_data_i (cfg_data_i),
            .step_i     (step_w[i]),
            .ptr_o      (ptr_w[i]),
            .cnt_o      (cnt_w[i]),
            .pend_o     (pend_w[i]),
            .done_o     (done_o[i])
        );
    end

    dma_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req0_i     (pend_w[0]),
        .req1_i     (pend_w[1] && (cnt_w[1] > cnt_w[0])),
        .cpu_busy_i (cpu_busy_i),
        .state_o    (state),
        .step0_o    (step_w[0]),
        .step1_o    (step_w[1]),
        .rd_o       (mem_rd_o),
        .wr_o       (mem_wr_o),
        .own_o      (dma_bus_o)
    );

    always_comb begin
        unique case (state)
            ST_RD0:  mem_addr_o = ptr_w[0];
            ST_WR0:  mem_addr_o = tmp_q;
            ST_RD1:  mem_addr_o = tmp_q;
            ST_WR1:  mem_addr_o = ptr_w[1];
            default: mem_addr_o = '0;
        endcase
    end

    assign mem_wdata_o = data_q;
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_busy_i,
    input logic          dma_bus_o,
    input logic          mem_rd_o,
    input logic          mem_wr_o,
    input logic [CW-1:0] cnt0,
    input logic [CW-1:0] cnt1
);
    AST_GRANT_CPU_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |-> $past(!cpu_busy_i)); // R5

    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> mem_wr_o); // R5

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> $past(mem_rd_o)); // R5

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o)); // R5

    AST_OWN_MATCHES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> dma_bus_o); // R5

    AST_CH1_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt1 >= cnt0); // R7
endmodule

bind dma_chain_top dma_chain_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_busy_i (cpu_busy_i),
    .dma_bus_o  (dma_bus_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .cnt0       (cnt_w[0]),
    .cnt1       (cnt_w[1])
);

// File: tb/tb_dma_chain_top.sv
module tb_dma_chain_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          trig = 1'b0;
    logic          cpu_busy = 1'b0;
    logic          dma_bus, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic [1:0]    done;

    int errors = 0;
    int checks = 0;

    logic [7:0]    mem [512];
    int            wn = 0;
    logic [AW-1:0] wprev = '0, wlast = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chain_top #(.AW(AW), .CW(8)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_data_i(cfg_data), .trig_i(trig), .cpu_busy_i(cpu_busy),
        .dma_bus_o(dma_bus), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
        .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .done_o(done)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] * 8'd7 + 8'd3;
    endfunction

    assign mem_rdata = (mem_addr < 16'h0100) ? pat(mem_addr) : mem[mem_addr[8:0]];

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[8:0]] <= mem_wdata;
            wprev <= wlast;
            wlast <= mem_addr;
            wn    <= wn + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rd", mem_rd, 0);
        check("R1 wr", mem_wr, 0);
        check("R1 own", dma_bus, 0);
        check("R1 done", done, 0);
    endtask

    task automatic t_single_copy();
        int w0;
        cfg(3'd0, 16'h0000);
        cfg(3'd1, 16'h01F0);
        cfg(3'd2, 16'h0100);
        cfg(3'd3, 16'd128);
        cfg(3'd4, 16'h0003);
        check("R8 done low after arm", done, 0);
        cfg(3'd0, 16'h0050);
        w0 = wn;
        pulse();
        idle(12);
        check("R9 writes per trigger", wn - w0, 2);
        check("R4 first write staging", wprev, 16'h01F0);
        check("R4 second write dest", wlast, 16'h0100);
        check("R2 src write ignored", mem[9'h100], pat(16'h0000));
    endtask

    task automatic t_double_trigger();
        int w0;
        w0 = wn;
        @(negedge clk) cpu_busy = 1'b1;
        pulse();
        pulse();
        idle(5);
        check("R5 no cycle while cpu busy", wn - w0, 0);
        check("R5 bus not owned", dma_bus, 0);
        @(negedge clk) cpu_busy = 1'b0;
        idle(20);
        check("R3 second trigger not counted", wn - w0, 2);
        check("R4 dest advanced", mem[9'h101], pat(16'h0001));
    endtask

    task automatic t_cpu_between();
        int w0;
        w0 = wn;
        pulse();
        while (!mem_wr) @(negedge clk);
        check("R4 ch0 writes staging", mem_addr, 16'h01F0);
        cpu_busy = 1'b1;
        idle(8);
        check("R6 ch1 waits for cpu", wn - w0, 1);
        @(negedge clk) cpu_busy = 1'b0;
        idle(10);
        check("R6 ch1 completes", wn - w0, 2);
        check("R6 dest byte", mem[9'h102], pat(16'h0002));
    endtask

    task automatic t_ch1_alone();
        int w0;
        cfg(3'd4, 16'h0000);
        cfg(3'd0, 16'h0010);
        cfg(3'd2, 16'h0140);
        cfg(3'd3, 16'd4);
        cfg(3'd4, 16'h0002);
        w0 = wn;
        pulse();
        idle(15);
        check("R7 ch1 alone no cycle", wn - w0, 0);
        cfg(3'd4, 16'h0003);
        pulse();
        idle(15);
        check("R7 pair runs once ch0 armed", wn - w0, 2);
        check("R7 dest byte", mem[9'h140], pat(16'h0010));
    endtask

    task automatic t_full_block();
        int w0;
        int bad;
        cfg(3'd4, 16'h0000);
        cfg(3'd0, 16'h0000);
        cfg(3'd2, 16'h0100);
        cfg(3'd3, 16'd128);
        cfg(3'd4, 16'h0003);
        for (int i = 0; i < 128; i++) begin
            pulse();
            idle(10);
        end
        bad = 0;
        for (int i = 0; i < 128; i++)
            if (mem[9'h100 + i] !== pat(AW'(i))) bad++;
        check("R9 block mismatches", bad, 0);
        check("R8 both done", done, 2'b11);
        w0 = wn;
        pulse();
        idle(12);
        check("R8 trigger after done ignored", wn - w0, 0);
        cfg(3'd4, 16'h0000);
        check("R8 done drops when disarmed", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_copy();
        t_double_trigger();
        t_cpu_between();
        t_ch1_alone();
        t_full_block();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule